// File: doc/BRIEF.md
# Cache Test Register Access Unit

This block gives processor test software a register-mapped way into a four-way set-associative cache. The cache's tag, data, valid and LRU storage is modelled inside the block. Software works through three test registers: a 32-bit data register, a status register and a control register. The cache lines are 128 bits wide, so the data register is a 32-bit window into two staging buffers. A fill buffer collects a line one word at a time before the line is written into the array. A read buffer holds a line copied out of the array, and software drains it one word at a time.

Each write to the control register carries a 2-bit operation code, a 2-bit entry select and an 8-bit set select. For buffer access the entry select picks a word inside a buffer. For array operations it picks a way inside the addressed set. A testability write stores the fill buffer into the array, together with the tag, valid bit and LRU value held in the status register. A testability read copies a way into the read buffer and returns the way's tag and valid bit, plus the set's LRU bits and all four of its valid bits, in the status register. A flush invalidates every way and clears all LRU state.

Test operations take effect only while both the cache-disable input and the no-write-through input are high. The results of a register write can be read in the clock cycle after the write.

Top module: `cache_test_regs`

## Requirements
- R1: After reset the data, status and control registers all read zero, and every way of every set is invalid.
- R2: The register address selects the register: 0 is data, 1 is status, 2 is control, and 3 always reads zero. Control fields are op[1:0], entry[3:2] and set[11:4]. Status fields are tag[28:8], valid[7], LRU[6:4] and set-valid[3:0], with bits 31:29 reading zero. Software can write the status register and read it back.
- R3: When the stored operation is 00, a data-register write goes into fill-buffer word `entry`, and a data-register read returns read-buffer word `entry`. Word 0 is line bits 31:0.
- R4: A control write with op 01 stores the fill buffer, the status tag, the status valid bit and the status LRU field into way `entry` of set `set`.
- R5: A control write with op 10 loads that way's line into the read buffer. It loads the status register with the way's tag and valid bit, the set's LRU bits, and the set's valid bits, where set-valid bit i belongs to way i. The array is left unchanged.
- R6: A control write with op 11 clears every valid bit and every LRU field in all sets.
- R7: Unless both cache_disable and no_write_through are high, fill-buffer writes and all array operations are ignored. The control register is still updated.
- R8: When the stored operation is not 00, a data-register read returns the last word written to the data register.
- R9: An operation on one set and way leaves every other set and way unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_disable | input | 1 | Cache-disable enable bit; must be high for test operations |
| no_write_through | input | 1 | No-write-through enable bit; must be high for test operations |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The assertions assume that reg_addr, reg_wdata and reg_wr are driven cleanly and are stable around the sampling edge. They also assume that at most one register write happens per cycle, which the single write strobe enforces. The bench changes every input at the falling edge and holds each write for exactly one cycle. It never checks the contents of a way it has not written, so unwritten storage can never decide a result. The two enable inputs change only between register accesses, so an operation never sees them mid-write.

// File: rtl/cache_test_pkg.sv
// Shared definitions for the cache test register unit.
// Assumes a 2-bit register address and a 2-bit operation field.
package cache_test_pkg;
    typedef enum logic [1:0] {
        OP_BUF   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_FLUSH = 2'b11
    } test_op_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_RSVD = 2'd3;
endpackage

// File: rtl/cache_test_ctrl.sv
// Register decode for the test unit. This module holds the control,
// status and data registers and produces the single-cycle operation strobes.
// Assumes at most one register write per cycle. An operation uses the
// set and way fields of the control word being written in that cycle.
module cache_test_ctrl
    import cache_test_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SEL_W  = 2,
    parameter int SET_W  = 8,
    parameter int STAT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              test_en,
    input  logic [STAT_W-1:0] rd_status,
    output logic [1:0]        op_q,
    output logic [SEL_W-1:0]  entry_q,
    output logic [SET_W-1:0]  set_q,
    output logic [STAT_W-1:0] status_q,
    output logic [WORD_W-1:0] data_q,
    output logic [SET_W-1:0]  act_set,
    output logic [SEL_W-1:0]  act_way,
    output logic              do_write,
    output logic              do_read,
    output logic              do_flush,
    output logic              fill_we
);
    logic       ctrl_wr;
    logic [1:0] new_op;

    // Decode the fields of an incoming control word.
    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
        new_op  = reg_wdata[1:0];
        act_way = reg_wdata[2 +: SEL_W];
        act_set = reg_wdata[2 + SEL_W +: SET_W];
    end

    // Gate the operation strobes with the test enable.
    always_comb begin
        do_write = ctrl_wr && test_en && (new_op == OP_WRITE);
        do_read  = ctrl_wr && test_en && (new_op == OP_READ);
        do_flush = ctrl_wr && test_en && (new_op == OP_FLUSH);
        fill_we  = reg_wr && (reg_addr == ADDR_DATA) && test_en && (op_q == OP_BUF);
    end

    // Control register: stored on every control write, enabled or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_BUF;
            entry_q <= '0;
            set_q   <= '0;
        end else if (ctrl_wr) begin
            op_q    <= new_op;
            entry_q <= act_way;
            set_q   <= act_set;
        end
    end

    // Status register: loaded by a testability read or by a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (do_read) begin
            status_q <= rd_status;
        end else if (reg_wr && (reg_addr == ADDR_STAT)) begin
            status_q <= reg_wdata[STAT_W-1:0];
        end
    end

    // Data register: keeps the last word software wrote to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (reg_wr && (reg_addr == ADDR_DATA)) begin
            data_q <= reg_wdata;
        end
    end
endmodule

// File: rtl/cache_test_buffers.sv
// Fill and read staging buffers, each one line of WORDS words.
// Assumes that WORDS equals 2**SEL_W, so the entry select addresses every word.
module cache_test_buffers #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int SEL_W  = 2,
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_we,
    input  logic [SEL_W-1:0]  entry,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rbuf_load,
    input  logic [LINE_W-1:0] line_in,
    output logic [LINE_W-1:0] fill_line,
    output logic [WORD_W-1:0] rbuf_word
);
    logic [WORD_W-1:0] fill_w [WORDS];
    logic [WORD_W-1:0] rbuf_w [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Write one fill word, selected by the entry field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fill_w[w] <= '0;
            end else if (fill_we && (entry == SEL_W'(w))) begin
                fill_w[w] <= wdata;
            end
        end

        // Capture one word of the line on a testability read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rbuf_w[w] <= '0;
            end else if (rbuf_load) begin
                rbuf_w[w] <= line_in[w*WORD_W +: WORD_W];
            end
        end

        assign fill_line[w*WORD_W +: WORD_W] = fill_w[w];
    end

    assign rbuf_word = rbuf_w[entry];
endmodule

// File: rtl/cache_test_array.sv
// Model of the cache storage: line data and tag per way, a valid bit per
// way and an LRU field per set. Reads are combinational. Writes and flushes
// take effect at the clock edge. Line data and tags are not reset.
module cache_test_array #(
    parameter int SETS   = 256,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 21,
    parameter int LINE_W = 128,
    localparam int SET_W = $clog2(SETS),
    localparam int SEL_W = $clog2(WAYS),
    localparam int LRU_W = WAYS - 1,
    localparam int IDX_W = SET_W + SEL_W,
    localparam int ENTRIES = SETS * WAYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              flush,
    input  logic [SET_W-1:0]  set,
    input  logic [SEL_W-1:0]  way,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_valid,
    input  logic [LRU_W-1:0]  wr_lru,
    output logic [LINE_W-1:0] rd_line,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [LRU_W-1:0]  rd_lru,
    output logic [WAYS-1:0]   rd_set_valid,
    output logic              valid_any
);
    logic [LINE_W-1:0] line_mem [ENTRIES];
    logic [TAG_W-1:0]  tag_mem  [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [LRU_W-1:0]  lru_q [SETS];
    logic [IDX_W-1:0]  idx;

    assign idx = {set, way};

    // Store line data and tag on a testability write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_mem[idx] <= wr_line;
            tag_mem[idx]  <= wr_tag;
        end
    end

    // Valid and LRU state: cleared by reset or flush, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                lru_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[idx] <= wr_valid;
            lru_q[set]   <= wr_lru;
        end
    end

    // Combinational read of the addressed way and its set.
    always_comb begin
        rd_line  = line_mem[idx];
        rd_tag   = tag_mem[idx];
        rd_valid = valid_q[idx];
        rd_lru   = lru_q[set];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_sv
        assign rd_set_valid[w] = valid_q[{set, SEL_W'(w)}];
    end

    assign valid_any = |valid_q;
endmodule

// File: rtl/cache_test_regs.sv
// Top of the cache test register unit. It connects the register decode,
// the staging buffers and the storage model, and drives the read mux.
// Assumes WORDS == WAYS == 2**SEL_W, and WORD_W wide enough to hold both
// the status word and the control word.
module cache_test_regs
    import cache_test_pkg::*;
#(
    parameter int SETS   = 256,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 21,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_disable,
    input  logic              no_write_through,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam int SET_W  = $clog2(SETS);
    localparam int SEL_W  = $clog2(WAYS);
    localparam int LRU_W  = WAYS - 1;
    localparam int LINE_W = WORD_W * WORDS;
    localparam int STAT_W = TAG_W + 1 + LRU_W + WAYS;
    localparam int CTRL_W = 2 + SEL_W + SET_W;

    logic              test_en;
    logic [1:0]        op_q;
    logic [SEL_W-1:0]  entry_q;
    logic [SET_W-1:0]  set_q;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] rd_status;
    logic [WORD_W-1:0] data_q;
    logic [SET_W-1:0]  act_set;
    logic [SEL_W-1:0]  act_way;
    logic              do_write, do_read, do_flush, fill_we;
    logic [LINE_W-1:0] fill_line, rd_line;
    logic [WORD_W-1:0] rbuf_word;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic [LRU_W-1:0]  rd_lru;
    logic [WAYS-1:0]   rd_set_valid;
    logic              valid_any;

    assign test_en   = cache_disable && no_write_through;
    assign rd_status = {rd_tag, rd_valid, rd_lru, rd_set_valid};

    cache_test_ctrl #(
        .WORD_W(WORD_W), .SEL_W(SEL_W), .SET_W(SET_W), .STAT_W(STAT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .test_en(test_en), .rd_status(rd_status),
        .op_q(op_q), .entry_q(entry_q), .set_q(set_q), .status_q(status_q),
        .data_q(data_q), .act_set(act_set), .act_way(act_way),
        .do_write(do_write), .do_read(do_read), .do_flush(do_flush),
        .fill_we(fill_we)
    );

    cache_test_buffers #(
        .WORD_W(WORD_W), .WORDS(WORDS), .SEL_W(SEL_W)
    ) u_bufs (
        .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .entry(entry_q),
        .wdata(reg_wdata), .rbuf_load(do_read), .line_in(rd_line),
        .fill_line(fill_line), .rbuf_word(rbuf_word)
    );

    cache_test_array #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(do_write), .flush(do_flush),
        .set(act_set), .way(act_way), .wr_line(fill_line),
        .wr_tag(status_q[STAT_W-1 -: TAG_W]),
        .wr_valid(status_q[WAYS + LRU_W]),
        .wr_lru(status_q[WAYS +: LRU_W]),
        .rd_line(rd_line), .rd_tag(rd_tag), .rd_valid(rd_valid),
        .rd_lru(rd_lru), .rd_set_valid(rd_set_valid), .valid_any(valid_any)
    );

    // Read mux: the data address gives the read buffer while the stored op is 00.
    always_comb begin
        unique case (reg_addr)
            ADDR_DATA: reg_rdata = (op_q == OP_BUF) ? rbuf_word : data_q;
            ADDR_STAT: reg_rdata = WORD_W'(status_q);
            ADDR_CTRL: reg_rdata = WORD_W'({set_q, entry_q, op_q});
            default:   reg_rdata = '0;
        endcase
    end

    logic [CTRL_W-1:0] unused_ctrl_w;
    assign unused_ctrl_w = {set_q, entry_q, op_q};
endmodule

// File: rtl/cache_test_regs_chk.sv
// Checker for cache_test_regs. It relates the port-level enable and write
// inputs to the internal operation strobes and to the storage summary.
module cache_test_regs_chk #(
    parameter int WORD_W = 32,
    parameter int LINE_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cache_disable,
    input logic              no_write_through,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [1:0]        new_op,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              do_write,
    input logic              do_read,
    input logic              do_flush,
    input logic              fill_we,
    input logic              valid_any,
    input logic [LINE_W-1:0] fill_line
);
    assert_no_op_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cache_disable && no_write_through) |-> !(do_write || do_read || do_flush || fill_we));

    assert_fill_held_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && !(cache_disable && no_write_through)) |=> $stable(fill_line));

    assert_single_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_write, do_read, do_flush}));

    assert_write_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && new_op == 2'b01 && cache_disable && no_write_through) |-> do_write);

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> !valid_any);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

bind cache_test_regs cache_test_regs_chk #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cache_disable(cache_disable),
    .no_write_through(no_write_through), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .new_op(reg_wdata[1:0]), .reg_rdata(reg_rdata), .do_write(do_write),
    .do_read(do_read), .do_flush(do_flush), .fill_we(fill_we),
    .valid_any(valid_any), .fill_line(fill_line)
);

// File: tb/cache_test_regs_tb.sv
module cache_test_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_disable = 1'b0;
    logic        no_write_through = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] pat [4];

    cache_test_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cache_disable(cache_disable),
        .no_write_through(no_write_through), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic logic [31:0] ctl(input logic [1:0] op, input logic [1:0] ent, input logic [7:0] st);
        return {20'b0, st, ent, op};
    endfunction

    function automatic logic [31:0] stw(input logic [20:0] tag, input logic v, input logic [2:0] lru, input logic [3:0] sv);
        return {3'b0, tag, v, lru, sv};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        n_run++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: addr %0d got %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic en(input logic on);
        cache_disable = on; no_write_through = on;
    endtask

    task automatic fill_line(input logic [31:0] base);
        for (int k = 0; k < 4; k++) begin
            wr(2'd2, ctl(2'b00, 2'(k), 8'd0));
            wr(2'd0, base + 32'(k) * 32'h0101_0101);
        end
    endtask

    task automatic t_reset;
        chk(2'd0, 32'h0, "R1");
        chk(2'd1, 32'h0, "R1");
        chk(2'd2, 32'h0, "R1");
        en(1'b1);
        wr(2'd2, ctl(2'b10, 2'd0, 8'd0));
        reg_addr = 2'd1; #1;
        n_run++;
        if (reg_rdata[7:0] !== 8'h00) begin
            n_fail++;
            $display("FAIL R1: valid bits got %h expected 00", reg_rdata[7:0]);
        end
    endtask

    task automatic t_regmap;
        wr(2'd1, 32'hFFFF_FFFF);
        chk(2'd1, 32'h1FFF_FFFF, "R2");
        chk(2'd3, 32'h0, "R2");
        wr(2'd2, ctl(2'b00, 2'd3, 8'hA5));
        chk(2'd2, 32'h0000_0A5C, "R2");
    endtask

    task automatic t_write_read;
        en(1'b1);
        fill_line(32'h1000_0000);
        wr(2'd1, stw(21'h12345, 1'b1, 3'd5, 4'h0));
        wr(2'd2, ctl(2'b01, 2'd2, 8'd7));
        wr(2'd1, 32'h0);
        wr(2'd2, ctl(2'b10, 2'd2, 8'd7));
        chk(2'd1, stw(21'h12345, 1'b1, 3'd5, 4'b0100), "R5");
        for (int k = 0; k < 4; k++) begin
            wr(2'd2, ctl(2'b00, 2'(k), 8'd0));
            chk(2'd0, 32'h1000_0000 + 32'(k) * 32'h0101_0101, "R3");
        end
        wr(2'd2, ctl(2'b10, 2'd2, 8'd7));
        chk(2'd1, stw(21'h12345, 1'b1, 3'd5, 4'b0100), "R5");
    endtask

    task automatic t_ways;
        en(1'b1);
        fill_line(32'h2000_0000);
        wr(2'd1, stw(21'h0AAAA, 1'b1, 3'd2, 4'h0));
        wr(2'd2, ctl(2'b01, 2'd0, 8'd255));
        fill_line(32'h3000_0000);
        wr(2'd1, stw(21'h1F00F, 1'b1, 3'd6, 4'h0));
        wr(2'd2, ctl(2'b01, 2'd3, 8'd255));
        wr(2'd2, ctl(2'b10, 2'd3, 8'd255));
        chk(2'd1, stw(21'h1F00F, 1'b1, 3'd6, 4'b1001), "R4");
        wr(2'd2, ctl(2'b10, 2'd0, 8'd255));
        chk(2'd1, stw(21'h0AAAA, 1'b1, 3'd6, 4'b1001), "R9");
        wr(2'd2, ctl(2'b00, 2'd1, 8'd0));
        chk(2'd0, 32'h2101_0101, "R4");
        wr(2'd2, ctl(2'b10, 2'd2, 8'd7));
        chk(2'd1, stw(21'h12345, 1'b1, 3'd5, 4'b0100), "R9");
    endtask

    task automatic t_data_reg;
        wr(2'd2, ctl(2'b10, 2'd2, 8'd7));
        wr(2'd0, 32'hCAFE_F00D);
        chk(2'd0, 32'hCAFE_F00D, "R8");
    endtask

    task automatic t_disabled;
        cache_disable = 1'b1; no_write_through = 1'b0;
        wr(2'd2, ctl(2'b00, 2'd0, 8'd0));
        wr(2'd0, 32'hDEAD_BEEF);
        wr(2'd1, stw(21'h00077, 1'b0, 3'd1, 4'h0));
        wr(2'd2, ctl(2'b01, 2'd2, 8'd7));
        chk(2'd2, ctl(2'b01, 2'd2, 8'd7), "R7");
        cache_disable = 1'b0; no_write_through = 1'b1;
        wr(2'd2, ctl(2'b11, 2'd0, 8'd0));
        en(1'b1);
        wr(2'd2, ctl(2'b10, 2'd2, 8'd7));
        chk(2'd1, stw(21'h12345, 1'b1, 3'd5, 4'b0100), "R7");
        wr(2'd1, stw(21'h00001, 1'b1, 3'd0, 4'h0));
        wr(2'd2, ctl(2'b01, 2'd0, 8'd1));
        wr(2'd2, ctl(2'b10, 2'd0, 8'd1));
        wr(2'd2, ctl(2'b00, 2'd0, 8'd0));
        chk(2'd0, 32'h3000_0000, "R7");
    endtask

    task automatic t_flush;
        en(1'b1);
        wr(2'd2, ctl(2'b11, 2'd0, 8'd0));
        wr(2'd2, ctl(2'b10, 2'd2, 8'd7));
        reg_addr = 2'd1; #1;
        n_run++;
        if (reg_rdata[7:0] !== 8'h00) begin
            n_fail++;
            $display("FAIL R6: set 7 valid/LRU got %h expected 00", reg_rdata[7:0]);
        end
        wr(2'd2, ctl(2'b10, 2'd3, 8'd255));
        reg_addr = 2'd1; #1;
        n_run++;
        if (reg_rdata[7:0] !== 8'h00) begin
            n_fail++;
            $display("FAIL R6: set 255 valid/LRU got %h expected 00", reg_rdata[7:0]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_write_read();
        t_ways();
        t_data_reg();
        t_disabled();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule